// File: doc/BRIEF.md
# Outstanding-Transaction Limit Sequencer

This block applies a new cap on in-flight bus transactions to one client of a shared memory fabric. A request names the client, the direction (read or write), whether the client is non-realtime, the frame geometry and rate, and which clock-gating control feeds that client. The sequencer first selects a limit. It starts from a per-direction default. For non-realtime clients it refines that default from a pixel-rate tier table. It then reads the limit already programmed for that client and direction, and stops early if nothing would change.

When an update is needed, the block drives a simple register master port through a fixed sequence:

1. Force the client clock on.
2. Read-modify-write the client's 8-bit limit field.
3. Raise the client's halt request.
4. Poll the halt acknowledge within a bounded time.
5. Drop the halt request.
6. Release the clock force, but only if this sequence was the one that applied it.

A one-cycle done pulse ends every request, and a timeout flag rides on that pulse.

The register slave returns read data on the cycle after a read strobe. Only one request is in flight at a time.

Top module: `ot_limit_seq`

## Requirements
- R1: After reset, req_ready is 1, done and timed_out are 0, and no register read or write is issued until a request is accepted.
- R2: With no table refinement, the chosen limit is DEF_RD_LIM (32) for a read request and DEF_WR_LIM (16) for a write request.
- R3: The pixel rate (fps × width × height, 64-bit) refines the limit only when req_nrt is 1 and the FEAT_EN parameter is 1. Otherwise the default is used unchanged.
- R4: Tiers are searched from the lowest bound upward. The first tier whose bound is at least the pixel rate supplies the limit: ≤62,668,800 gives 2, ≤125,337,600 gives 4, ≤248,832,000 gives 16. Above the last bound the default stays.
- R5: The limit lives in byte lane (client mod 4) of word LIM_RD_BASE + client/4 (read) or LIM_WR_BASE + client/4 (write), with bases 0x10 and 0x14. It is written by read-modify-write, leaving the other three bytes unchanged.
- R6: The clock force is bit 0 of word CLKF_BASE (0x40) + clock select. The sequence always writes it set. It writes it clear at the end only if it read back clear before forcing.
- R7: Register writes occur in this order: clock force set, limit word, halt control with the client bit set (word 0x20, bit = client), halt control with that bit clear, clock force clear.
- R8: If the programmed byte already equals the chosen limit, the request ends with a single read and no writes, and done rises 4 cycles after the accepting edge.
- R9: A clock select of 0 or of NUM_CLK_SEL (17) or above touches no clock-force register, and the rest of the sequence still runs.
- R10: Halt acknowledge is bit client of word 0x21. If it is not seen by TIMEOUT_US microseconds (US_CYCLES cycles each), it is sampled once more. If it is still clear, timed_out is 1 with done, and the halt request is still cleared afterwards.
- R11: A chosen limit of 0, from a zero default, ends the request with no register access. Done rises 3 cycles after the accepting edge.
- R12: req_ready is 1 only while idle. done is a single-cycle pulse, and no second request is accepted until it has been given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request taken when valid |
| req_client | input | CID_W | Bus client index |
| req_rd | input | 1 | 1 = read limit, 0 = write limit |
| req_nrt | input | 1 | Client is non-realtime (enables tier refinement) |
| req_width | input | W_W | Frame width in pixels |
| req_height | input | H_W | Frame height in lines |
| req_fps | input | FPS_W | Frame rate |
| req_clk_sel | input | CSEL_W | Clock-force control select |
| reg_rd_en | output | 1 | Register read strobe |
| reg_wr_en | output | 1 | Register write strobe |
| reg_addr | output | ADDR_W | Register word address |
| reg_wdata | output | DATA_W | Register write data |
| reg_rdata | input | DATA_W | Read data, valid the cycle after reg_rd_en |
| done | output | 1 | One-cycle completion pulse |
| timed_out | output | 1 | Halt wait expired (valid with done) |

## Verification
The accepting edge is the cycle reference. A zero-limit request pulses done on the third edge after it, and an unchanged limit pulses done on the fourth, because the tier pick is registered and the comparison waits one cycle for read data. The bench counts falling edges from acceptance and checks those two paths for exact equality. Longer paths depend on the halt acknowledge, so for them the bench waits for done while confirming that req_ready stays low. It then compares the ordered register-write log, and for the timeout case it checks that the elapsed cycles are at least the programmed window.

// File: rtl/ot_seq_pkg.sv
// Package: shared state encoding and pixel-rate tier table for the
// outstanding-transaction limit sequencer.
// Assumes: tier bounds are listed in ascending order.
package ot_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_CALC, ST_CHECK, ST_LIMCMP,
        ST_CLKSET, ST_LIMWR, ST_HALTRD, ST_HALTSET,
        ST_POLLRD, ST_POLLCHK, ST_WAIT, ST_UNRD,
        ST_UNWR, ST_RELRD, ST_RELWR, ST_DONE
    } seq_state_t;

    localparam int N_TIERS = 3;

    localparam logic [63:0] TIER_BOUND [N_TIERS] = '{
        64'(1088 * 1920 * 30),
        64'(1088 * 1920 * 60),
        64'(3840 * 2160 * 30)
    };

    localparam logic [7:0] TIER_LIMIT [N_TIERS] = '{8'd2, 8'd4, 8'd16};

endpackage

// File: rtl/ot_rate_pick.sv
// Module: picks the transaction limit for a captured request.
// It starts from the per-direction default. When the client is
// non-realtime and the feature is enabled, it replaces that default
// with the first tier whose bound covers the pixel rate.
// Assumes: inputs are stable while calc_en is high; the result is
// registered on that edge and truncated to 8 bits.
module ot_rate_pick
    import ot_seq_pkg::*;
#(
    parameter int W_W        = 16,
    parameter int H_W        = 16,
    parameter int FPS_W      = 8,
    parameter int DEF_RD_LIM = 32,
    parameter int DEF_WR_LIM = 16,
    parameter bit FEAT_EN    = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             calc_en,
    input  logic             rd,
    input  logic             nrt,
    input  logic [W_W-1:0]   width,
    input  logic [H_W-1:0]   height,
    input  logic [FPS_W-1:0] fps,
    output logic [7:0]       lim
);

    logic [63:0]        pix_rate;
    logic [N_TIERS-1:0] tier_hit;
    logic [31:0]        base_lim;
    logic [31:0]        pick;

    // Pixel rate at full 64-bit width.
    assign pix_rate = 64'(fps) * 64'(width) * 64'(height);

    // One comparator per tier.
    for (genvar t = 0; t < N_TIERS; t++) begin : g_tier
        assign tier_hit[t] = (pix_rate <= TIER_BOUND[t]);
    end

    // Default for the direction, then the lowest matching tier.
    always_comb begin
        logic found;
        base_lim = rd ? 32'(DEF_RD_LIM) : 32'(DEF_WR_LIM);
        pick     = base_lim;
        found    = 1'b0;
        if (FEAT_EN && nrt && (base_lim != 32'd0)) begin
            for (int t = 0; t < N_TIERS; t++) begin
                if (tier_hit[t] && !found) begin
                    pick  = 32'(TIER_LIMIT[t]);
                    found = 1'b1;
                end
            end
        end
    end

    // Register the truncated limit.
    always_ff @(posedge clk) begin
        if (!rst_n)       lim <= 8'd0;
        else if (calc_en) lim <= pick[7:0];
    end

endmodule

// File: rtl/ot_halt_timer.sv
// Module: microsecond deadline counter for the halt-acknowledge wait.
// It divides the clock by US_CYCLES to form microsecond ticks and
// saturates at TIMEOUT_US.
// Assumes: clr is pulsed when the halt request is raised.
module ot_halt_timer #(
    parameter int US_CYCLES  = 250,
    parameter int TIMEOUT_US = 16384
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic expired
);

    localparam int PW = $clog2(US_CYCLES + 1);
    localparam int TW = $clog2(TIMEOUT_US + 1);

    logic [PW-1:0] pre_q;
    logic [TW-1:0] us_q;

    assign expired = (us_q >= TW'(TIMEOUT_US));

    // Prescaler and saturating microsecond count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pre_q <= '0;
            us_q  <= '0;
        end else if (!expired) begin
            if (pre_q == PW'(US_CYCLES - 1)) begin
                pre_q <= '0;
                us_q  <= us_q + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ot_limit_seq.sv
// Module: top of the outstanding-transaction limit sequencer.
// It accepts one request, picks a limit, and skips the request when the
// limit is zero or already programmed. Otherwise it runs the sequence
// clock force, limit write, halt, poll, unhalt, conditional release
// over a register master port.
// Assumes: read data arrives the cycle after reg_rd_en; 2**CID_W <= DATA_W.
module ot_limit_seq
    import ot_seq_pkg::*;
#(
    parameter int CID_W          = 4,
    parameter int W_W            = 16,
    parameter int H_W            = 16,
    parameter int FPS_W          = 8,
    parameter int CSEL_W         = 5,
    parameter int NUM_CLK_SEL    = 17,
    parameter int ADDR_W         = 8,
    parameter int DATA_W         = 32,
    parameter int DEF_RD_LIM     = 32,
    parameter int DEF_WR_LIM     = 16,
    parameter bit FEAT_EN        = 1'b1,
    parameter int US_CYCLES      = 250,
    parameter int TIMEOUT_US     = 16384,
    parameter int POLL_CYCLES    = 16,
    parameter int LIM_RD_BASE    = 'h10,
    parameter int LIM_WR_BASE    = 'h14,
    parameter int HALT_CTRL_ADDR = 'h20,
    parameter int HALT_STAT_ADDR = 'h21,
    parameter int CLKF_BASE      = 'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CID_W-1:0]  req_client,
    input  logic              req_rd,
    input  logic              req_nrt,
    input  logic [W_W-1:0]    req_width,
    input  logic [H_W-1:0]    req_height,
    input  logic [FPS_W-1:0]  req_fps,
    input  logic [CSEL_W-1:0] req_clk_sel,
    output logic              reg_rd_en,
    output logic              reg_wr_en,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              done,
    output logic              timed_out
);

    localparam int LANES = DATA_W / 8;
    localparam int LW    = $clog2(LANES);
    localparam int SHW   = LW + 3;
    localparam int PCW   = $clog2(POLL_CYCLES + 1);

    seq_state_t        st;
    logic [CID_W-1:0]  cid_q;
    logic              rd_q, nrt_q;
    logic [W_W-1:0]    w_q;
    logic [H_W-1:0]    h_q;
    logic [FPS_W-1:0]  fps_q;
    logic [CSEL_W-1:0] sel_q;
    logic [DATA_W-1:0] word_q;
    logic              forced_q, to_q, final_q;
    logic [PCW-1:0]    poll_q;

    logic [7:0]        lim;
    logic              expired;
    logic              sel_ok;
    logic [SHW-1:0]    sh;
    logic [7:0]        cur_byte;
    logic [ADDR_W-1:0] lim_addr, clkf_addr;
    logic [DATA_W-1:0] halt_bit, lane_mask;
    logic              ack;

    // Limit selection for the captured request.
    ot_rate_pick #(
        .W_W(W_W), .H_W(H_W), .FPS_W(FPS_W),
        .DEF_RD_LIM(DEF_RD_LIM), .DEF_WR_LIM(DEF_WR_LIM), .FEAT_EN(FEAT_EN)
    ) u_pick (
        .clk(clk), .rst_n(rst_n), .calc_en(st == ST_CALC),
        .rd(rd_q), .nrt(nrt_q), .width(w_q), .height(h_q), .fps(fps_q),
        .lim(lim)
    );

    // Deadline for the halt-acknowledge wait.
    ot_halt_timer #(.US_CYCLES(US_CYCLES), .TIMEOUT_US(TIMEOUT_US)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clr(st == ST_HALTSET), .expired(expired)
    );

    // Address, lane and mask helpers for the captured request.
    always_comb begin
        sel_ok    = (sel_q != '0) && (32'(sel_q) < NUM_CLK_SEL);
        sh        = {cid_q[LW-1:0], 3'b000};
        cur_byte  = 8'(reg_rdata >> sh);
        lim_addr  = ADDR_W'(rd_q ? LIM_RD_BASE : LIM_WR_BASE) + ADDR_W'(cid_q >> LW);
        clkf_addr = ADDR_W'(CLKF_BASE) + ADDR_W'(sel_q);
        halt_bit  = DATA_W'(1) << cid_q;
        lane_mask = DATA_W'(8'hFF) << sh;
        ack       = (reg_rdata & halt_bit) != '0;
    end

    // Register master strobes, address and data per state.
    always_comb begin
        reg_rd_en = 1'b0;
        reg_wr_en = 1'b0;
        reg_addr  = '0;
        reg_wdata = '0;
        case (st)
            ST_CHECK:   if (lim != 8'd0) begin reg_rd_en = 1'b1; reg_addr = lim_addr; end
            ST_LIMCMP:  if (cur_byte != lim && sel_ok) begin reg_rd_en = 1'b1; reg_addr = clkf_addr; end
            ST_CLKSET:  begin reg_wr_en = 1'b1; reg_addr = clkf_addr; reg_wdata = reg_rdata | DATA_W'(1); end
            ST_LIMWR:   begin
                reg_wr_en = 1'b1;
                reg_addr  = lim_addr;
                reg_wdata = (word_q & ~lane_mask) | (DATA_W'(lim) << sh);
            end
            ST_HALTRD:  begin reg_rd_en = 1'b1; reg_addr = ADDR_W'(HALT_CTRL_ADDR); end
            ST_HALTSET: begin reg_wr_en = 1'b1; reg_addr = ADDR_W'(HALT_CTRL_ADDR); reg_wdata = reg_rdata | halt_bit; end
            ST_POLLRD:  begin reg_rd_en = 1'b1; reg_addr = ADDR_W'(HALT_STAT_ADDR); end
            ST_UNRD:    begin reg_rd_en = 1'b1; reg_addr = ADDR_W'(HALT_CTRL_ADDR); end
            ST_UNWR:    begin reg_wr_en = 1'b1; reg_addr = ADDR_W'(HALT_CTRL_ADDR); reg_wdata = reg_rdata & ~halt_bit; end
            ST_RELRD:   begin reg_rd_en = 1'b1; reg_addr = clkf_addr; end
            ST_RELWR:   begin reg_wr_en = 1'b1; reg_addr = clkf_addr; reg_wdata = reg_rdata & ~DATA_W'(1); end
            default: ;
        endcase
    end

    assign req_ready = (st == ST_IDLE);
    assign done      = (st == ST_DONE);
    assign timed_out = (st == ST_DONE) && to_q;

    // Sequence state, request capture and status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            cid_q    <= '0;
            rd_q     <= 1'b0;
            nrt_q    <= 1'b0;
            w_q      <= '0;
            h_q      <= '0;
            fps_q    <= '0;
            sel_q    <= '0;
            word_q   <= '0;
            forced_q <= 1'b0;
            to_q     <= 1'b0;
            final_q  <= 1'b0;
            poll_q   <= '0;
        end else begin
            case (st)
                ST_IDLE: if (req_valid) begin
                    cid_q    <= req_client;
                    rd_q     <= req_rd;
                    nrt_q    <= req_nrt;
                    w_q      <= req_width;
                    h_q      <= req_height;
                    fps_q    <= req_fps;
                    sel_q    <= req_clk_sel;
                    forced_q <= 1'b0;
                    to_q     <= 1'b0;
                    final_q  <= 1'b0;
                    st       <= ST_CALC;
                end
                ST_CALC:  st <= ST_CHECK;
                ST_CHECK: st <= (lim == 8'd0) ? ST_DONE : ST_LIMCMP;
                ST_LIMCMP: begin
                    word_q <= reg_rdata;
                    if (cur_byte == lim) st <= ST_DONE;
                    else                 st <= sel_ok ? ST_CLKSET : ST_LIMWR;
                end
                ST_CLKSET: begin
                    forced_q <= ~reg_rdata[0];
                    st       <= ST_LIMWR;
                end
                ST_LIMWR:   st <= ST_HALTRD;
                ST_HALTRD:  st <= ST_HALTSET;
                ST_HALTSET: st <= ST_POLLRD;
                ST_POLLRD:  st <= ST_POLLCHK;
                ST_POLLCHK: begin
                    if (ack) begin
                        st <= ST_UNRD;
                    end else if (final_q) begin
                        to_q <= 1'b1;
                        st   <= ST_UNRD;
                    end else if (expired) begin
                        final_q <= 1'b1;
                        st      <= ST_POLLRD;
                    end else begin
                        poll_q <= '0;
                        st     <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (poll_q == PCW'(POLL_CYCLES - 1)) st <= ST_POLLRD;
                    else                                  poll_q <= poll_q + 1'b1;
                end
                ST_UNRD:  st <= ST_UNWR;
                ST_UNWR:  st <= forced_q ? ST_RELRD : ST_DONE;
                ST_RELRD: st <= ST_RELWR;
                ST_RELWR: st <= ST_DONE;
                default:  st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ot_limit_seq_chk.sv
// Module: property checker for the limit sequencer, bound to every instance.
// It tracks the accepted client and the last halt-control write for
// that client, so the halt state at completion can be checked.
module ot_limit_seq_chk #(
    parameter int CID_W          = 4,
    parameter int ADDR_W         = 8,
    parameter int DATA_W         = 32,
    parameter int HALT_CTRL_ADDR = 'h20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [CID_W-1:0]  req_client,
    input logic              reg_rd_en,
    input logic              reg_wr_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              done,
    input logic              timed_out
);

    logic [CID_W-1:0] cid_c;
    logic             halt_held;
    logic             busy_c;

    // Track the client in flight and its halt-request bit as written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cid_c     <= '0;
            halt_held <= 1'b0;
            busy_c    <= 1'b0;
        end else begin
            if (req_valid && req_ready) begin
                cid_c  <= req_client;
                busy_c <= 1'b1;
            end else if (done) begin
                busy_c <= 1'b0;
            end
            if (reg_wr_en && reg_addr == ADDR_W'(HALT_CTRL_ADDR))
                halt_held <= reg_wdata[cid_c];
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !(reg_rd_en || reg_wr_en));

    assert_single_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd_en && reg_wr_en));

    assert_flag_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        timed_out |-> done);

    assert_halt_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !halt_held);

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_after_accept_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_done_owned_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy_c);

endmodule

bind ot_limit_seq ot_limit_seq_chk #(
    .CID_W(CID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HALT_CTRL_ADDR(HALT_CTRL_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_client(req_client), .reg_rd_en(reg_rd_en), .reg_wr_en(reg_wr_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .done(done), .timed_out(timed_out)
);

// File: tb/ot_limit_seq_tb.sv
`timescale 1ns/1ps
module ot_limit_seq_tb;

    localparam int US_CYC = 4;
    localparam int TO_US  = 20;
    localparam int ACK_DLY = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_valid = 1'b0, b_valid = 1'b0;
    logic        a_ready, b_ready;
    logic [3:0]  client = '0;
    logic        rd = 1'b0, nrt = 1'b0;
    logic [15:0] width = '0, height = '0;
    logic [7:0]  fps = '0;
    logic [4:0]  csel = '0;

    logic        a_rd_en, a_wr_en, b_rd_en, b_wr_en;
    logic [7:0]  a_addr, b_addr;
    logic [31:0] a_wdata, b_wdata;
    logic [31:0] a_rdata, b_rdata;
    logic        a_done, a_to, b_done, b_to;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    ot_limit_seq #(.US_CYCLES(US_CYC), .TIMEOUT_US(TO_US), .POLL_CYCLES(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(a_valid), .req_ready(a_ready),
        .req_client(client), .req_rd(rd), .req_nrt(nrt), .req_width(width),
        .req_height(height), .req_fps(fps), .req_clk_sel(csel),
        .reg_rd_en(a_rd_en), .reg_wr_en(a_wr_en), .reg_addr(a_addr),
        .reg_wdata(a_wdata), .reg_rdata(a_rdata), .done(a_done), .timed_out(a_to)
    );

    // Second instance: zero write default and tier refinement disabled.
    ot_limit_seq #(.US_CYCLES(US_CYC), .TIMEOUT_US(TO_US), .POLL_CYCLES(3),
                   .DEF_WR_LIM(0), .FEAT_EN(1'b0)) u_dut_b (
        .clk(clk), .rst_n(rst_n), .req_valid(b_valid), .req_ready(b_ready),
        .req_client(client), .req_rd(rd), .req_nrt(nrt), .req_width(width),
        .req_height(height), .req_fps(fps), .req_clk_sel(csel),
        .reg_rd_en(b_rd_en), .reg_wr_en(b_wr_en), .reg_addr(b_addr),
        .reg_wdata(b_wdata), .reg_rdata(b_rdata), .done(b_done), .timed_out(b_to)
    );

    // Register slave model for u_dut, with a write log and halt acknowledge.
    logic [31:0] mem [256];
    logic [7:0]  lg_a [32];
    logic [31:0] lg_d [32];
    int          lg_n, rd_n, ack_cnt;
    logic        ack_en = 1'b1;
    logic        clr_log = 1'b0;
    logic        pre_en = 1'b0;
    logic [7:0]  pre_addr = '0;
    logic [31:0] pre_data = '0;
    logic [31:0] stat;

    assign stat = (ack_en && ack_cnt >= ACK_DLY) ? mem[8'h20] : 32'd0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= '0;
            lg_n <= 0; rd_n <= 0; ack_cnt <= 0; a_rdata <= '0;
        end else begin
            if (a_rd_en) begin
                a_rdata <= (a_addr == 8'h21) ? stat : mem[a_addr];
                rd_n    <= clr_log ? 0 : rd_n + 1;
            end else if (clr_log) rd_n <= 0;
            if (a_wr_en) begin
                mem[a_addr] <= a_wdata;
                if (lg_n < 32) begin
                    lg_a[lg_n] <= a_addr;
                    lg_d[lg_n] <= a_wdata;
                end
                lg_n <= clr_log ? 0 : lg_n + 1;
            end else if (clr_log) lg_n <= 0;
            if (pre_en) mem[pre_addr] <= pre_data;
            ack_cnt <= (mem[8'h20] != 0) ? ack_cnt + 1 : 0;
        end
    end

    // Minimal slave for u_dut_b: acknowledges halt at once, logs the limit word.
    int          b_acc;
    logic [31:0] b_limw;
    always @(posedge clk) begin
        if (!rst_n) begin
            b_acc <= 0; b_limw <= '0; b_rdata <= '0;
        end else begin
            if (b_rd_en) b_rdata <= (b_addr == 8'h21) ? 32'hFFFF_FFFF : 32'd0;
            if (b_rd_en || b_wr_en) b_acc <= b_acc + 1;
            if (b_wr_en && b_addr == 8'h10) b_limw <= b_wdata;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_wr(input int idx, input logic [7:0] ea, input logic [31:0] ed,
                          input string req);
        chk(lg_a[idx] == ea && lg_d[idx] == ed, req, $sformatf("write #%0d", idx),
            {lg_a[idx], lg_d[idx]}, {ea, ed});
    endtask

    task automatic preset(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); pre_en = 1'b1; pre_addr = a; pre_data = d;
        @(negedge clk); pre_en = 1'b0;
    endtask

    // Issue one request to instance a (sel_b=0) or b (sel_b=1).
    // Returns the negedge count k (1 = first negedge after acceptance) at done.
    task automatic run_req(input bit sel_b, input logic [3:0] c, input bit r, input bit n,
                           input int w, input int h, input int f, input int cs,
                           output int k, output bit to);
        bit busy_ok;
        @(negedge clk);
        clr_log = 1'b1;
        client = c; rd = r; nrt = n; width = 16'(w); height = 16'(h); fps = 8'(f);
        csel = 5'(cs);
        if (sel_b) b_valid = 1'b1; else a_valid = 1'b1;
        @(negedge clk);
        clr_log = 1'b0; a_valid = 1'b0; b_valid = 1'b0;
        k = 1; busy_ok = 1'b1;
        while (!(sel_b ? b_done : a_done) && k < 3000) begin
            if (sel_b ? b_ready : a_ready) busy_ok = 1'b0;
            @(negedge clk); k++;
        end
        to = sel_b ? b_to : a_to;
        chk(busy_ok, "R12", "ready low while busy", busy_ok, 1);
        @(negedge clk);
        chk(!(sel_b ? b_done : a_done), "R12", "done single cycle", 0, 0);
    endtask

    task automatic t_reset;
        chk(a_ready && !a_done && !a_to && !a_rd_en && !a_wr_en, "R1", "idle a",
            {a_ready, a_done, a_to, a_rd_en, a_wr_en}, 5'b10000);
        chk(b_ready && !b_done && !b_rd_en && !b_wr_en, "R1", "idle b",
            {b_ready, b_done, b_rd_en, b_wr_en}, 4'b1000);
    endtask

    task automatic t_default_rt;
        int k; bit to;
        preset(8'h11, 32'hAABB00CC);
        run_req(1'b0, 4'd5, 1'b1, 1'b0, 640, 480, 60, 3, k, to);
        chk(lg_n == 5, "R7", "write count", lg_n, 5);
        chk_wr(0, 8'h43, 32'h1, "R6");
        chk_wr(1, 8'h11, 32'hAABB20CC, "R2 R5");
        chk_wr(2, 8'h20, 32'h20, "R7");
        chk_wr(3, 8'h20, 32'h0, "R7");
        chk_wr(4, 8'h43, 32'h0, "R6");
        chk(!to, "R10", "no timeout with ack", to, 0);
    endtask

    task automatic t_tiers_wr;
        int k; bit to;
        run_req(1'b0, 4'd2, 1'b0, 1'b1, 1920, 1088, 30, 14, k, to);
        chk_wr(1, 8'h14, 32'h0002_0000, "R4 tier bound equal");
        run_req(1'b0, 4'd2, 1'b0, 1'b1, 1920, 1088, 31, 14, k, to);
        chk_wr(1, 8'h14, 32'h0004_0000, "R4 second tier");
    endtask

    task automatic t_tiers_rd;
        int k; bit to;
        run_req(1'b0, 4'd8, 1'b1, 1'b1, 3840, 2160, 30, 7, k, to);
        chk_wr(1, 8'h12, 32'h10, "R4 top tier");
        run_req(1'b0, 4'd8, 1'b1, 1'b1, 3840, 2160, 31, 7, k, to);
        chk_wr(1, 8'h12, 32'h20, "R4 above table keeps default");
    endtask

    task automatic t_equal_skip;
        int k; bit to;
        run_req(1'b0, 4'd8, 1'b1, 1'b0, 100, 100, 60, 7, k, to);
        chk(lg_n == 0, "R8", "no writes", lg_n, 0);
        chk(rd_n == 1, "R8", "single read", rd_n, 1);
        chk(k == 4, "R8", "done cycle", k, 4);
    endtask

    task automatic t_preforced;
        int k; bit to;
        preset(8'h45, 32'h1);
        run_req(1'b0, 4'd1, 1'b0, 1'b0, 100, 100, 60, 5, k, to);
        chk(lg_n == 4, "R6", "no release write", lg_n, 4);
        chk_wr(0, 8'h45, 32'h1, "R6");
        chk_wr(1, 8'h14, 32'h0004_1000, "R2 R5");
        chk_wr(3, 8'h20, 32'h0, "R7");
    endtask

    task automatic t_bad_sel;
        int k; bit to;
        run_req(1'b0, 4'd12, 1'b0, 1'b0, 100, 100, 60, 0, k, to);
        chk(lg_n == 3, "R9", "sel 0 write count", lg_n, 3);
        chk_wr(0, 8'h17, 32'h10, "R9");
        chk_wr(1, 8'h20, 32'h1000, "R9");
        run_req(1'b0, 4'd13, 1'b0, 1'b0, 100, 100, 60, 17, k, to);
        chk(lg_n == 3, "R9", "sel 17 write count", lg_n, 3);
        chk_wr(0, 8'h17, 32'h1010, "R9");
    endtask

    task automatic t_timeout;
        int k; bit to;
        ack_en = 1'b0;
        run_req(1'b0, 4'd4, 1'b1, 1'b0, 100, 100, 60, 2, k, to);
        ack_en = 1'b1;
        chk(to, "R10", "timed_out", to, 1);
        chk(k >= TO_US * US_CYC, "R10", "waited full window", k, TO_US * US_CYC);
        chk(lg_n == 5, "R10", "write count", lg_n, 5);
        chk_wr(3, 8'h20, 32'h0, "R10 halt cleared");
        chk_wr(4, 8'h42, 32'h0, "R10 release");
    endtask

    task automatic t_inst_b;
        int k; bit to; int acc0;
        acc0 = b_acc;
        run_req(1'b1, 4'd0, 1'b0, 1'b0, 100, 100, 60, 1, k, to);
        chk(b_acc == acc0, "R11", "no access", b_acc, acc0);
        chk(k == 3, "R11", "done cycle", k, 3);
        run_req(1'b1, 4'd0, 1'b1, 1'b1, 1920, 1088, 30, 1, k, to);
        chk(b_limw == 32'h20, "R3", "feature off keeps default", b_limw, 32'h20);
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_default_rt();
        t_tiers_wr();
        t_tiers_rd();
        t_equal_skip();
        t_preforced();
        t_bad_sel();
        t_timeout();
        t_inst_b();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule